// File: doc/BRIEF.md
# Undervoltage and Thermal Fault Supervisor

This block watches a set of single-bit undervoltage flags and two thermal flags, and turns them into one registered fault output and the protective actions a power controller needs. The flags come from three groups of monitors: regulated outputs whose pass device sits inside the chip, regulated outputs whose pass device sits outside, and the main supply inputs. A flag only counts once it has stayed high for a programmable number of microsecond ticks, so short dips are ignored. A sequencer arms or disarms each monitor to match the current power-up phase.

What a confirmed flag does depends on its group. On an output with an external pass device it only raises the fault. On an output with an internal pass device it also latches that one regulator off. Losing a main supply while the system is active raises the fault and a latched request to the state controller to enter the soft-off state. The lower thermal level only raises the fault. The upper thermal level turns every output off for as long as it persists. A shutdown request forces the fault low and clears every latch.

Top module: `uv_fault_supervisor`

## Requirements
- R1: A flag is confirmed only after its raw input has been high, with the monitor armed, on TMO_TICKS clock cycles that carry `tick_i`. The count is kept only while the flag is high. A low raw input or a disarm clears it, and cycles without `tick_i` do not add to it. Every output responds on the clock edge after confirmation.
- R2: A disarmed monitor never confirms and never changes any output, whatever its raw input does.
- R3: A confirmed flag on an external-pass output raises `fault_o` only. `reg_off_o`, `all_off_o` and `force_s5_o` stay low, and the fault clears once the flag is no longer confirmed.
- R4: A confirmed flag on internal-pass output i raises `fault_o` and sets bit i of `reg_off_o`, which is 1 for "regulator disabled". Both stay set after the flag drops, and no other bit changes.
- R5: A confirmed thermal warning raises `fault_o` only. No regulator is disabled.
- R6: A confirmed thermal shutdown drives `all_off_o` high together with `fault_o`. `all_off_o` returns low one edge after the shutdown flag stops being confirmed, while a still-present warning keeps `fault_o` high. This repeats each time the shutdown flag returns.
- R7: A confirmed supply flag while `active_i` is high raises `fault_o` and a latched `force_s5_o`. The latch holds after `active_i` falls and clears only when no supply flag is confirmed. A confirmed supply flag while inactive changes nothing.
- R8: While `shut_req_i` is high, `fault_o`, every `reg_off_o` bit and `force_s5_o` are low from the next clock edge on. An internal-pass fault still confirmed after release latches again.
- R9: `fault_o` is registered. It is the OR of every live confirmed condition and every latched condition, and it falls one edge after the last of them goes away.
- R10: While `rst_n` is low, every output is low, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle microsecond tick that advances debounce counters |
| int_uv_i | input | N_INT | Raw undervoltage flags, internal-pass outputs |
| int_arm_i | input | N_INT | Arm enables for internal-pass monitors |
| ext_uv_i | input | N_EXT | Raw undervoltage flags, external-pass outputs |
| ext_arm_i | input | N_EXT | Arm enables for external-pass monitors |
| sup_uv_i | input | N_SUP | Raw undervoltage flags, main supply inputs |
| sup_arm_i | input | N_SUP | Arm enables for supply monitors |
| therm_warn_i | input | 1 | Raw thermal warning flag (lower level) |
| therm_shut_i | input | 1 | Raw thermal shutdown flag (upper level) |
| active_i | input | 1 | High while the system is in an active state |
| shut_req_i | input | 1 | Shutdown request (soft-start node below its threshold) |
| fault_o | output | 1 | Registered fault indication |
| reg_off_o | output | N_INT | Per-regulator latched disable, bit i for internal output i |
| all_off_o | output | 1 | Thermal shutdown of every output |
| force_s5_o | output | 1 | Latched request to enter the soft-off state |

## Verification
Each monitor is tried with a single raw pulse, both armed and disarmed, for every hold length from one tick up to two past the timeout. Sampling while the pulse is held, one edge after it drops and three edges after it drops shows which of live fault, latched disable, thermal cut-off and soft-off request that monitor's group produces. The boundary lengths TMO_TICKS-1, TMO_TICKS and TMO_TICKS+1 separate a dip that is too short from one that is confirmed and from one that shows at the ports while it is still held. Directed runs cover a hold that is broken and restarted, a hold with no ticks, supply loss before and after the active state, a shutdown request over a latched regulator, and thermal shutdown cycling under a standing warning.

// File: rtl/uvs_pkg.sv
package uvs_pkg;
  // Width of a saturating counter that must reach the value n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/uvs_qual_bank.sv
module uvs_qual_bank
  import uvs_pkg::*;
#(
  parameter int LANES     = 1,
  parameter int TMO_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [LANES-1:0] raw_i,
  input  logic [LANES-1:0] arm_i,
  output logic [LANES-1:0] qual_o
);
  localparam int              CW    = cnt_width(TMO_TICKS);
  localparam logic [CW-1:0]   LIMIT = CW'(TMO_TICKS);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hold;
    logic          step_en;

    assign hold    = raw_i[g] & arm_i[g];
    assign step_en = hold & tick_i & (cnt_q != LIMIT);

    always_comb begin
      cnt_d = cnt_q;
      if (!hold)        cnt_d = '0;
      else if (step_en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign qual_o[g] = (cnt_q == LIMIT);

    // R1: a confirmed lane had its flag held and armed on the previous cycle
    p_qual_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      qual_o[g] |-> $past(raw_i[g] && arm_i[g]));
    // R2: disarming removes confirmation by the next edge
    p_disarm_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i[g] |=> !qual_o[g]);
  end
endmodule

// File: rtl/uvs_latchoff.sv
module uvs_latchoff #(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [LANES-1:0] trip_i,
  output logic [LANES-1:0] off_o
);
  logic [LANES-1:0] off_q, off_d;

  always_comb begin
    if (clear_i) off_d = '0;
    else         off_d = off_q | trip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  assign off_o = off_q;

  // R8: a clear empties every latch on the next edge
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (off_o == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4: a latched regulator stays off until cleared
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (off_o[g] && !clear_i) |=> off_o[g]);
    // R4: a latch only sets from its own lane's trip
    p_latch_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(off_o[g]) |-> $past(trip_i[g]));
  end
endmodule

// File: rtl/uv_fault_supervisor.sv
module uv_fault_supervisor #(
  parameter int N_INT     = 2,
  parameter int N_EXT     = 3,
  parameter int N_SUP     = 3,
  parameter int TMO_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [N_INT-1:0] int_uv_i,
  input  logic [N_INT-1:0] int_arm_i,
  input  logic [N_EXT-1:0] ext_uv_i,
  input  logic [N_EXT-1:0] ext_arm_i,
  input  logic [N_SUP-1:0] sup_uv_i,
  input  logic [N_SUP-1:0] sup_arm_i,
  input  logic             therm_warn_i,
  input  logic             therm_shut_i,
  input  logic             active_i,
  input  logic             shut_req_i,
  output logic             fault_o,
  output logic [N_INT-1:0] reg_off_o,
  output logic             all_off_o,
  output logic             force_s5_o
);
  logic [N_INT-1:0] int_q;
  logic [N_EXT-1:0] ext_q;
  logic [N_SUP-1:0] sup_q;
  logic [1:0]       therm_q;   // [0] warning, [1] shutdown
  logic [N_INT-1:0] off_q;
  logic             sup_any;
  logic             fault_q, fault_d;
  logic             s5_q, s5_d;
  logic             cut_q, cut_d;

  uvs_qual_bank #(.LANES(N_INT), .TMO_TICKS(TMO_TICKS)) u_int_qual (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .raw_i(int_uv_i), .arm_i(int_arm_i), .qual_o(int_q));

  uvs_qual_bank #(.LANES(N_EXT), .TMO_TICKS(TMO_TICKS)) u_ext_qual (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .raw_i(ext_uv_i), .arm_i(ext_arm_i), .qual_o(ext_q));

  uvs_qual_bank #(.LANES(N_SUP), .TMO_TICKS(TMO_TICKS)) u_sup_qual (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .raw_i(sup_uv_i), .arm_i(sup_arm_i), .qual_o(sup_q));

  uvs_qual_bank #(.LANES(2), .TMO_TICKS(TMO_TICKS)) u_therm_qual (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .raw_i({therm_shut_i, therm_warn_i}), .arm_i(2'b11), .qual_o(therm_q));

  uvs_latchoff #(.LANES(N_INT)) u_latch (
    .clk(clk), .rst_n(rst_n), .clear_i(shut_req_i),
    .trip_i(int_q), .off_o(off_q));

  assign sup_any = |sup_q;

  always_comb begin
    // soft-off request: set by supply loss in the active state, held
    // until every supply monitor is clear
    if (shut_req_i)  s5_d = 1'b0;
    else if (s5_q)   s5_d = sup_any;
    else             s5_d = sup_any & active_i;

    cut_d = therm_q[1];

    fault_d = ~shut_req_i & ( (|int_q) | (|ext_q) | (|therm_q)
                            | (sup_any & active_i)
                            | (|off_q) | s5_q );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      s5_q    <= 1'b0;
      cut_q   <= 1'b0;
    end else begin
      fault_q <= fault_d;
      s5_q    <= s5_d;
      cut_q   <= cut_d;
    end
  end

  assign fault_o    = fault_q;
  assign reg_off_o  = off_q;
  assign all_off_o  = cut_q;
  assign force_s5_o = s5_q;

  // R8: a shutdown request silences the fault on the next edge
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req_i |=> !fault_o);
  // R7: the soft-off request only starts from the active state
  p_s5_from_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_s5_o) |-> $past(active_i));
  // R8: no soft-off request survives a shutdown request
  p_s5_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req_i |=> !force_s5_o);
endmodule

// File: tb/uv_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module uv_fault_supervisor_tb_top;
  localparam int NI  = 2;
  localparam int NE  = 2;
  localparam int NS  = 3;
  localparam int TMO = 4;
  localparam int NM  = NI + NE + NS + 2;  // monitors: int, ext, sup, warn, shut

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          tick;
  logic [NI-1:0] int_uv, int_arm;
  logic [NE-1:0] ext_uv, ext_arm;
  logic [NS-1:0] sup_uv, sup_arm;
  logic          warn, shut, active, shut_req;
  logic          fault_o, all_off_o, force_s5_o;
  logic [NI-1:0] reg_off_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  uv_fault_supervisor #(.N_INT(NI), .N_EXT(NE), .N_SUP(NS), .TMO_TICKS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .int_uv_i(int_uv), .int_arm_i(int_arm),
    .ext_uv_i(ext_uv), .ext_arm_i(ext_arm),
    .sup_uv_i(sup_uv), .sup_arm_i(sup_arm),
    .therm_warn_i(warn), .therm_shut_i(shut),
    .active_i(active), .shut_req_i(shut_req),
    .fault_o(fault_o), .reg_off_o(reg_off_o),
    .all_off_o(all_off_o), .force_s5_o(force_s5_o));

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [NI-1:0] bit_of(input int m);
    logic [NI-1:0] r = '0;
    if (m >= 0 && m < NI) r[m] = 1'b1;
    return r;
  endfunction

  task automatic expect_out(input string tag, input logic f, input logic ao,
                            input logic s5, input logic [NI-1:0] ro);
    n_chk++;
    if ({fault_o, all_off_o, force_s5_o, reg_off_o} !== {f, ao, s5, ro}) begin
      n_bad++;
      $display("FAIL %s: actual fault=%b all_off=%b force_s5=%b reg_off=%b, expected fault=%b all_off=%b force_s5=%b reg_off=%b",
               tag, fault_o, all_off_o, force_s5_o, reg_off_o, f, ao, s5, ro);
    end
  endtask

  task automatic set_raw(input int m, input logic v);
    if (m < NI)                int_uv[m] = v;
    else if (m < NI + NE)      ext_uv[m - NI] = v;
    else if (m < NI + NE + NS) sup_uv[m - NI - NE] = v;
    else if (m == NI + NE + NS) warn = v;
    else                        shut = v;
  endtask

  task automatic set_arm(input int m, input logic v);
    if (m < NI)                int_arm[m] = v;
    else if (m < NI + NE)      ext_arm[m - NI] = v;
    else if (m < NI + NE + NS) sup_arm[m - NI - NE] = v;
  endtask

  task automatic clear_all();
    int_uv = '0; ext_uv = '0; sup_uv = '0; warn = 1'b0; shut = 1'b0;
    int_arm = '1; ext_arm = '1; sup_arm = '1;
    tick = 1'b1; active = 1'b1;
    shut_req = 1'b1; cyc(2);
    shut_req = 1'b0; cyc(1);
  endtask

  // expected bundle for monitor m when its confirmed effect is v
  task automatic expect_mon(input string tag, input int m, input logic v);
    logic is_int, is_sup, is_shut;
    is_int  = (m < NI);
    is_sup  = (m >= NI + NE) && (m < NI + NE + NS);
    is_shut = (m == NI + NE + NS + 1);
    expect_out(tag, v, v & is_shut, v & is_sup, v ? bit_of(is_int ? m : -1) : '0);
  endtask

  initial begin
    rst_n = 1'b0;
    clear_all();
    // R10: flags high during reset must not reach the outputs
    int_uv = '1; ext_uv = '1; sup_uv = '1; warn = 1'b1; shut = 1'b1;
    cyc(TMO + 3);
    expect_out("R10 reset state", 1'b0, 1'b0, 1'b0, '0);
    int_uv = '0; ext_uv = '0; sup_uv = '0; warn = 1'b0; shut = 1'b0;
    rst_n = 1'b1;
    cyc(2);
    expect_out("R10 after release", 1'b0, 1'b0, 1'b0, '0);

    // Sweep: every monitor, armed and disarmed, every hold length
    for (int m = 0; m < NM; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int len = 1; len <= TMO + 2; len++) begin
          string cls;
          logic  ea, live, hit, is_int;
          is_int = (m < NI);
          if (m < NI)                cls = "R4 internal";
          else if (m < NI + NE)      cls = "R3 external";
          else if (m < NI + NE + NS) cls = "R7 supply";
          else if (m == NI + NE + NS) cls = "R5 warning";
          else                        cls = "R6 shutdown";
          ea = (m >= NI + NE + NS) ? 1'b1 : logic'(a);
          if (!ea) cls = "R2 disarmed";
          live = ea && (len >= TMO + 1);
          hit  = ea && (len >= TMO);
          clear_all();
          set_arm(m, logic'(a));
          set_raw(m, 1'b1);
          cyc(len);
          expect_mon($sformatf("R1 %s mon%0d hold%0d held", cls, m, len), m, live);
          set_raw(m, 1'b0);
          cyc(1);
          expect_mon($sformatf("R1 %s mon%0d hold%0d dropped", cls, m, len), m, hit);
          cyc(2);
          expect_out($sformatf("R9 %s mon%0d hold%0d settled", cls, m, len),
                     hit & is_int, 1'b0, 1'b0, (hit & is_int) ? bit_of(m) : '0);
        end
      end
    end

    // R1: a broken hold restarts the count
    clear_all();
    int_uv[0] = 1'b1; cyc(TMO - 1);
    int_uv[0] = 1'b0; cyc(1);
    int_uv[0] = 1'b1; cyc(TMO - 1);
    expect_out("R1 broken hold", 1'b0, 1'b0, 1'b0, '0);
    cyc(2);
    expect_out("R1 restarted hold", 1'b1, 1'b0, 1'b0, 2'b01);

    // R1: no tick, no progress
    clear_all();
    tick = 1'b0; int_uv[1] = 1'b1; cyc(3 * TMO);
    expect_out("R1 no tick", 1'b0, 1'b0, 1'b0, '0);
    tick = 1'b1; cyc(TMO + 1);
    expect_out("R1 ticks resume", 1'b1, 1'b0, 1'b0, 2'b10);

    // R7: supply loss outside the active state, then inside
    clear_all();
    active = 1'b0; sup_uv[0] = 1'b1; cyc(TMO + 3);
    expect_out("R7 inactive supply loss", 1'b0, 1'b0, 1'b0, '0);
    active = 1'b1; cyc(1);
    expect_out("R7 active supply loss", 1'b1, 1'b0, 1'b1, '0);
    active = 1'b0; cyc(2);
    expect_out("R7 request held after leaving active", 1'b1, 1'b0, 1'b1, '0);
    sup_uv[0] = 1'b0; cyc(3);
    expect_out("R7 request released on recovery", 1'b0, 1'b0, 1'b0, '0);

    // R8: shutdown request over a latched regulator
    clear_all();
    int_uv[0] = 1'b1; cyc(TMO + 1);
    expect_out("R4 latched before request", 1'b1, 1'b0, 1'b0, 2'b01);
    shut_req = 1'b1; cyc(1);
    expect_out("R8 request clears", 1'b0, 1'b0, 1'b0, '0);
    cyc(2);
    expect_out("R8 request holds clear", 1'b0, 1'b0, 1'b0, '0);
    shut_req = 1'b0; cyc(1);
    expect_out("R8 relatch after release", 1'b1, 1'b0, 1'b0, 2'b01);
    int_uv[0] = 1'b0; shut_req = 1'b1; cyc(1);
    shut_req = 1'b0; cyc(1);
    expect_out("R8 cleared for good", 1'b0, 1'b0, 1'b0, '0);

    // R6: thermal shutdown cycling under a standing warning
    clear_all();
    warn = 1'b1; shut = 1'b1; cyc(TMO + 1);
    expect_out("R6 both thermal levels", 1'b1, 1'b1, 1'b0, '0);
    shut = 1'b0; cyc(2);
    expect_out("R6 resume at warning level", 1'b1, 1'b0, 1'b0, '0);
    shut = 1'b1; cyc(TMO + 1);
    expect_out("R6 shutdown again", 1'b1, 1'b1, 1'b0, '0);
    warn = 1'b0; shut = 1'b0; cyc(3);
    expect_out("R5 thermal clear", 1'b0, 1'b0, 1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule